// File: doc/BRIEF.md
# Widening Integer Sum Reduction

This unit folds a stream of vector elements into one scalar whose width is twice the selected element width. A start pulse captures the operation: the element width, the register-group multiplier exponent, the signed or unsigned variant, the active length, whether masking is in force, and a seed scalar. The seed is taken at the doubled width. After the start, the unit accepts one element per clock whenever the element valid strobe is high. Each accepted element is extended to the doubled width, by sign or by zeros, and is added into the running sum unless its mask bit rules it out.

Once the last active-length element has been accepted, the unit raises a one-cycle completion pulse. In the same cycle it gives a write strobe for element 0 of the destination and a pulse that tells the surrounding pipeline to clear its vector start index. It does nothing else to the destination. An operation with zero length completes without writing. A configuration that cannot hold the widened result completes at once with an illegal flag and no write.

Top module: `wide_red_unit`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `result_we_o`, `illegal_o` and `vstart_clr_o` are low. A start is accepted only while `busy_o` is low. A start raised while busy is ignored and does not change the running operation or its result.
- R2: A legal start with nonzero length loads the accumulator from the low 2×SEW bits of `seed_i`. Seed bits above 2×SEW are ignored.
- R3: With `signed_i` = 0, each active element is zero-extended from its low SEW bits to 2×SEW before it is added. Element bits above SEW are ignored. The `sew_i` codes are 0 for 8 bits, 1 for 16 bits and 2 for 32 bits.
- R4: With `signed_i` = 1, each active element is sign-extended from bit SEW−1 to 2×SEW before it is added.
- R5: The sum wraps modulo 2^(2×SEW) and no overflow indication exists. Whenever `result_we_o` is high, every bit of `result_o` at or above position 2×SEW is zero.
- R6: With `mask_en_i` = 1, an accepted element whose `elem_mask_i` is 0 adds nothing. With `mask_en_i` = 0, every accepted element is added, whatever its mask bit.
- R7: While busy, one element is accepted on each clock edge at which `elem_valid_i` is high, and idle cycles are allowed. `done_o`, `result_we_o` and `vstart_clr_o` are high for exactly the one cycle after the edge that accepted element number vl−1, and `busy_o` falls in that same cycle.
- R8: A legal start with `vl_i` = 0 gives `done_o` high in the next cycle, with `result_we_o`, `vstart_clr_o` and `illegal_o` low. The unit does not become busy.
- R9: A start is illegal when any of these holds: `sew_i` = 3; `lmul_i` (a signed log2 of the group multiplier) is 3'b100; `lmul_i`+1 > 3; or log2(2×SEW) − (`lmul_i`+1) > log2(2×MAX_SEW). An illegal start gives `done_o` and `illegal_o` high in the next cycle, with no write and no busy period.
- R10: `elem_valid_i` pulses that arrive while the unit is idle have no effect on any later result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse for a reduction |
| sew_i | input | 2 | Element width code (0:8, 1:16, 2:32, 3 reserved) |
| lmul_i | input | 3 | Signed log2 of the group multiplier for the source |
| signed_i | input | 1 | 1 selects sign extension, 0 selects zero extension |
| vl_i | input | VL_W | Active length |
| mask_en_i | input | 1 | 1 makes per-element mask bits take effect |
| seed_i | input | ACC_W | Seed scalar (element 0 of the scalar source) |
| elem_valid_i | input | 1 | Element strobe |
| elem_i | input | MAX_SEW | Source element, in the low SEW bits |
| elem_mask_i | input | 1 | Mask bit belonging to `elem_i` |
| busy_o | output | 1 | Reduction in progress |
| done_o | output | 1 | Completion pulse |
| result_we_o | output | 1 | Write strobe for destination element 0 |
| result_o | output | ACC_W | Widened sum |
| illegal_o | output | 1 | Configuration rejected |
| vstart_clr_o | output | 1 | Clear the vector start index |

## Verification
The assertions check on every cycle how a start resolves: an illegal start flags and completes, a zero-length start completes without writing, and a legal start turns busy. They also check that a busy unit with no element strobe neither completes nor drops busy, that the fall of busy always comes with a write, and that a written result has no bits above 2×SEW. The arithmetic can only be shown by the bench scenarios, which compare each cycle against a behavioural model. These cover zero against sign extension, modulo wrap, masking on and off, seed truncation, ignored upper element bits, strobes with gaps, a start during a busy period, and strobes while idle.

// File: rtl/wred_pkg.sv
// Package: shared types and encodings for the widening reduction unit.
// Assumes element widths are powers of two starting at 8 bits.
package wred_pkg;

    // Control state of the reduction sequencer.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } wred_state_e;

    // Width of the element-width code field.
    localparam int SEW_CODE_W = 2;

    // Encoding of the element-width code.
    localparam logic [SEW_CODE_W-1:0] SEW_CODE_8  = 2'd0;
    localparam logic [SEW_CODE_W-1:0] SEW_CODE_16 = 2'd1;
    localparam logic [SEW_CODE_W-1:0] SEW_CODE_32 = 2'd2;

    // Reserved group-multiplier exponent code.
    localparam logic [2:0] LMUL_RESERVED = 3'b100;

    // Largest widened group-multiplier exponent allowed (x8).
    localparam int LMUL_W_MAX = 3;

endpackage

// File: rtl/wred_cfg_check.sv
// Module: decides whether a width / group-multiplier pair can hold the
// widened result. Purely combinational. Assumes ELEN = 2 x MAX_SEW and
// that codes at or above NUM_SEW are not supported.
module wred_cfg_check
    import wred_pkg::*;
#(
    parameter int MAX_SEW = 32
) (
    input  logic [SEW_CODE_W-1:0] sew_i,
    input  logic [2:0]            lmul_i,
    output logic                  legal_o
);
    localparam int NUM_SEW  = $clog2(MAX_SEW / 8) + 1;
    localparam int LOG_ELEN = $clog2(2 * MAX_SEW);

    int lm_w;
    int log_sew_w;

    // Apply every legality rule to the widened configuration.
    always_comb begin
        lm_w      = int'($signed(lmul_i)) + 1;
        log_sew_w = 4 + int'(sew_i);
        legal_o   = 1'b1;
        if (int'(sew_i) >= NUM_SEW) begin
            legal_o = 1'b0;
        end
        if (lmul_i == LMUL_RESERVED) begin
            legal_o = 1'b0;
        end
        if (lm_w > LMUL_W_MAX) begin
            legal_o = 1'b0;
        end
        if ((log_sew_w - lm_w) > LOG_ELEN) begin
            legal_o = 1'b0;
        end
    end

endmodule

// File: rtl/wred_extend.sv
// Module: extends one source element to accumulator width by zeros or by
// its sign bit, at the element width picked by the code. Combinational.
// Assumes ACC_W is larger than every supported element width.
module wred_extend
    import wred_pkg::*;
#(
    parameter int MAX_SEW = 32,
    parameter int ACC_W   = 2 * MAX_SEW
) (
    input  logic [MAX_SEW-1:0]    elem_i,
    input  logic [SEW_CODE_W-1:0] sew_i,
    input  logic                  signed_i,
    output logic [ACC_W-1:0]      ext_o
);
    localparam int NUM_SEW = $clog2(MAX_SEW / 8) + 1;

    logic [ACC_W-1:0] cand [NUM_SEW];

    for (genvar g = 0; g < NUM_SEW; g++) begin : g_width
        localparam int W = 8 << g;
        logic [ACC_W-1:0] zx;
        logic [ACC_W-1:0] sx;
        assign zx      = {{(ACC_W - W){1'b0}}, elem_i[W-1:0]};
        assign sx      = {{(ACC_W - W){elem_i[W-1]}}, elem_i[W-1:0]};
        assign cand[g] = signed_i ? sx : zx;
    end

    // Select the candidate that matches the width code.
    always_comb begin
        ext_o = '0;
        for (int k = 0; k < NUM_SEW; k++) begin
            if (sew_i == SEW_CODE_W'(k)) begin
                ext_o = cand[k];
            end
        end
    end

endmodule

// File: rtl/wred_ctrl.sv
// Module: sequencer for one reduction. It accepts a start only when idle,
// counts the accepted elements down to the last one, and produces the
// registered completion, write and illegal pulses. Assumes vl_i and the
// legality verdict are valid in the start cycle.
module wred_ctrl
    import wred_pkg::*;
#(
    parameter int VL_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            legal_i,
    input  logic [VL_W-1:0] vl_i,
    input  logic            elem_valid_i,
    output logic            busy_o,
    output logic            load_o,
    output logic            step_o,
    output logic            done_o,
    output logic            write_o,
    output logic            illegal_o
);
    wred_state_e     state_q;
    logic [VL_W-1:0] remain_q;
    logic            accept;
    logic            zero_len;
    logic            last;

    assign busy_o   = (state_q == ST_RUN);
    assign accept   = start_i && (state_q == ST_IDLE);
    assign zero_len = (vl_i == '0);
    assign load_o   = accept && legal_i && !zero_len;
    assign step_o   = busy_o && elem_valid_i;
    assign last     = step_o && (remain_q == '0);

    // Advance the idle / run state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else if (load_o) begin
            state_q <= ST_RUN;
        end else if (last) begin
            state_q <= ST_IDLE;
        end
    end

    // Track how many elements remain after the current one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (load_o) begin
            remain_q <= vl_i - 1'b1;
        end else if (step_o) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    // Register the one-cycle completion pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o    <= 1'b0;
            write_o   <= 1'b0;
            illegal_o <= 1'b0;
        end else begin
            done_o    <= last || (accept && (!legal_i || zero_len));
            write_o   <= last;
            illegal_o <= accept && !legal_i;
        end
    end

endmodule

// File: rtl/wred_accum.sv
// Module: the double-width accumulator. It loads the truncated seed and
// adds active extended elements modulo the width given by the mask.
// Assumes the caller supplies the mask for the width now in use.
module wred_accum #(
    parameter int ACC_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [ACC_W-1:0] seed_i,
    input  logic             add_i,
    input  logic [ACC_W-1:0] ext_i,
    input  logic [ACC_W-1:0] wmask_i,
    output logic [ACC_W-1:0] acc_o
);
    logic [ACC_W-1:0] acc_q;

    assign acc_o = acc_q;

    // Seed on load, otherwise add the active element with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (load_i) begin
            acc_q <= seed_i & wmask_i;
        end else if (add_i) begin
            acc_q <= (acc_q + ext_i) & wmask_i;
        end
    end

endmodule

// File: rtl/wide_red_unit.sv
// Module: top of the widening integer sum reduction. It latches the
// operation settings at start, extends each streamed element, applies the
// mask and sums into a 2 x SEW scalar. Assumes one element per valid strobe
// and no back-pressure. Destination elements other than 0 are not touched.
module wide_red_unit
    import wred_pkg::*;
#(
    parameter int MAX_SEW = 32,
    parameter int VL_W    = 8,
    parameter int ACC_W   = 2 * MAX_SEW
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [SEW_CODE_W-1:0] sew_i,
    input  logic [2:0]            lmul_i,
    input  logic                  signed_i,
    input  logic [VL_W-1:0]       vl_i,
    input  logic                  mask_en_i,
    input  logic [ACC_W-1:0]      seed_i,
    input  logic                  elem_valid_i,
    input  logic [MAX_SEW-1:0]    elem_i,
    input  logic                  elem_mask_i,
    output logic                  busy_o,
    output logic                  done_o,
    output logic                  result_we_o,
    output logic [ACC_W-1:0]      result_o,
    output logic                  illegal_o,
    output logic                  vstart_clr_o
);
    logic                  cfg_legal;
    logic                  load;
    logic                  step;
    logic                  write;
    logic [SEW_CODE_W-1:0] sew_q;
    logic                  sgn_q;
    logic                  men_q;
    logic [ACC_W-1:0]      ext;
    logic [ACC_W-1:0]      wmask;
    logic                  active;

    // Ones below bit 2 x SEW for the given width code.
    function automatic logic [ACC_W-1:0] width_mask(input logic [SEW_CODE_W-1:0] code);
        logic [ACC_W-1:0] m;
        for (int i = 0; i < ACC_W; i++) begin
            m[i] = (i < (16 << code));
        end
        return m;
    endfunction

    wred_cfg_check #(.MAX_SEW(MAX_SEW)) cfg_i (
        .sew_i  (sew_i),
        .lmul_i (lmul_i),
        .legal_o(cfg_legal)
    );

    wred_ctrl #(.VL_W(VL_W)) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .legal_i     (cfg_legal),
        .vl_i        (vl_i),
        .elem_valid_i(elem_valid_i),
        .busy_o      (busy_o),
        .load_o      (load),
        .step_o      (step),
        .done_o      (done_o),
        .write_o     (write),
        .illegal_o   (illegal_o)
    );

    // Hold the settings of the running operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sew_q <= SEW_CODE_8;
            sgn_q <= 1'b0;
            men_q <= 1'b0;
        end else if (load) begin
            sew_q <= sew_i;
            sgn_q <= signed_i;
            men_q <= mask_en_i;
        end
    end

    wred_extend #(.MAX_SEW(MAX_SEW), .ACC_W(ACC_W)) ext_i (
        .elem_i  (elem_i),
        .sew_i   (sew_q),
        .signed_i(sgn_q),
        .ext_o   (ext)
    );

    // Mask width follows the incoming code at load, the latched code after.
    always_comb begin
        wmask = load ? width_mask(sew_i) : width_mask(sew_q);
    end

    assign active = step && (!men_q || elem_mask_i);

    wred_accum #(.ACC_W(ACC_W)) acc_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .seed_i (seed_i),
        .add_i  (active),
        .ext_i  (ext),
        .wmask_i(wmask),
        .acc_o  (result_o)
    );

    assign result_we_o  = write;
    assign vstart_clr_o = write;

endmodule

// File: rtl/wred_checker.sv
// Module: protocol checker for the widening reduction unit, bound to the
// top. It observes ports plus the latched width code and legality verdict.
module wred_checker
    import wred_pkg::*;
#(
    parameter int ACC_W = 64,
    parameter int VL_W  = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  start_i,
    input logic [VL_W-1:0]       vl_i,
    input logic                  elem_valid_i,
    input logic                  cfg_legal,
    input logic [SEW_CODE_W-1:0] sew_q,
    input logic                  busy_o,
    input logic                  done_o,
    input logic                  result_we_o,
    input logic [ACC_W-1:0]      result_o,
    input logic                  illegal_o,
    input logic                  vstart_clr_o
);
    // Ones below bit 2 x SEW, computed independently of the design.
    function automatic logic [ACC_W-1:0] upper_zero_mask(input logic [SEW_CODE_W-1:0] code);
        logic [ACC_W-1:0] m;
        for (int i = 0; i < ACC_W; i++) begin
            m[i] = (i < 2 * (8 << code));
        end
        return m;
    endfunction

    assert_start_runs_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && cfg_legal && (vl_i != '0)) |=> (busy_o && !done_o));

    assert_wrap_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        result_we_o |-> ((result_o & ~upper_zero_mask(sew_q)) == '0));

    assert_wait_no_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !elem_valid_i) |=> (busy_o && !done_o));

    assert_finish_writes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (done_o && result_we_o && vstart_clr_o && !illegal_o));

    assert_zero_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && cfg_legal && (vl_i == '0)) |=>
        (done_o && !result_we_o && !vstart_clr_o && !illegal_o && !busy_o));

    assert_illegal_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && !cfg_legal) |=>
        (done_o && illegal_o && !result_we_o && !busy_o));

endmodule

bind wide_red_unit wred_checker #(.ACC_W(ACC_W), .VL_W(VL_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .vl_i        (vl_i),
    .elem_valid_i(elem_valid_i),
    .cfg_legal   (cfg_legal),
    .sew_q       (sew_q),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .result_we_o (result_we_o),
    .result_o    (result_o),
    .illegal_o   (illegal_o),
    .vstart_clr_o(vstart_clr_o)
);

// File: tb/wide_red_unit_tb_top.sv
module wide_red_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_SEW    = 32;
    localparam int VL_W       = 8;
    localparam int ACC_W      = 64;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start_i = 1'b0;
    logic [1:0]         sew_i = 2'd0;
    logic [2:0]         lmul_i = 3'd0;
    logic               signed_i = 1'b0;
    logic [VL_W-1:0]    vl_i = '0;
    logic               mask_en_i = 1'b0;
    logic [ACC_W-1:0]   seed_i = '0;
    logic               elem_valid_i = 1'b0;
    logic [MAX_SEW-1:0] elem_i = '0;
    logic               elem_mask_i = 1'b0;
    logic               busy_o, done_o, result_we_o, illegal_o, vstart_clr_o;
    logic [ACC_W-1:0]   result_o;

    int    checks = 0;
    int    fails  = 0;
    bit    ended  = 0;
    string cur_tag = "R1";

    wide_red_unit #(.MAX_SEW(MAX_SEW), .VL_W(VL_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .sew_i(sew_i),
        .lmul_i(lmul_i), .signed_i(signed_i), .vl_i(vl_i),
        .mask_en_i(mask_en_i), .seed_i(seed_i), .elem_valid_i(elem_valid_i),
        .elem_i(elem_i), .elem_mask_i(elem_mask_i), .busy_o(busy_o),
        .done_o(done_o), .result_we_o(result_we_o), .result_o(result_o),
        .illegal_o(illegal_o), .vstart_clr_o(vstart_clr_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", cur_tag, what, act, exp);
        end
    endtask

    function automatic logic [63:0] ones(input int n);
        return (n >= 64) ? '1 : ((64'd1 << n) - 64'd1);
    endfunction

    // Legality from R9, written as width arithmetic.
    function automatic bit cfg_ok(input int code, input int lm);
        int lw;
        if (code > 2) return 0;
        if (lm == -4) return 0;
        lw = lm + 1;
        if (lw > 3) return 0;
        return ((4 + code - lw) <= 6);
    endfunction

    // Behavioural reference model, advanced at each rising edge.
    bit          m_busy = 0, m_done = 0, m_we = 0, m_ill = 0;
    logic [63:0] m_res = '0;
    int          m_left = 0, m_sew = 8;
    bit          m_sgn = 0, m_men = 0;

    always @(posedge clk) begin : model
        bit          was_busy;
        logic [63:0] e;
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_we = 0; m_ill = 0; m_res = '0;
        end else begin
            was_busy = m_busy;
            m_done = 0; m_we = 0; m_ill = 0;
            if (!was_busy && start_i) begin
                if (!cfg_ok(int'(sew_i), int'($signed(lmul_i)))) begin
                    m_done = 1; m_ill = 1;
                end else if (vl_i == 0) begin
                    m_done = 1;
                end else begin
                    m_busy = 1;
                    m_sew  = 8 << sew_i;
                    m_sgn  = signed_i;
                    m_men  = mask_en_i;
                    m_left = int'(vl_i);
                    m_res  = seed_i & ones(2 * m_sew);
                end
            end else if (was_busy && elem_valid_i) begin
                e = 64'(elem_i) & ones(m_sew);
                if (m_sgn && e[m_sew-1]) e = e | ~ones(m_sew);
                if (!m_men || elem_mask_i) m_res = (m_res + e) & ones(2 * m_sew);
                m_left--;
                if (m_left == 0) begin
                    m_busy = 0; m_done = 1; m_we = 1;
                end
            end
        end
    end

    // Cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !ended) begin
            check(busy_o == m_busy, "busy_o", 64'(busy_o), 64'(m_busy));
            check(done_o == m_done, "done_o", 64'(done_o), 64'(m_done));
            check(result_we_o == m_we, "result_we_o", 64'(result_we_o), 64'(m_we));
            check(vstart_clr_o == m_we, "vstart_clr_o", 64'(vstart_clr_o), 64'(m_we));
            check(illegal_o == m_ill, "illegal_o", 64'(illegal_o), 64'(m_ill));
            if (m_we) check(result_o == m_res, "result_o", result_o, m_res);
        end
    end

    // kind: 0 writes a result, 1 zero length, 2 illegal.
    task automatic run_op(input string tag, input logic [1:0] sew,
                          input logic [2:0] lmul, input bit sgn, input int vl,
                          input bit men, input logic [63:0] seed,
                          input logic [31:0] el [8], input bit mk [8],
                          input int gap, input bit poke,
                          input logic [63:0] exp_res, input int kind);
        cur_tag = tag;
        @(negedge clk);
        start_i = 1; sew_i = sew; lmul_i = lmul; signed_i = sgn;
        vl_i = VL_W'(vl); mask_en_i = men; seed_i = seed;
        @(negedge clk);
        start_i = 0;
        if (kind != 0) begin
            check(done_o == 1'b1, "done after start", 64'(done_o), 64'd1);
            check(illegal_o == (kind == 2), "illegal flag", 64'(illegal_o), 64'(kind == 2));
            check(result_we_o == 1'b0, "no write", 64'(result_we_o), 64'd0);
            check(vstart_clr_o == 1'b0, "no vstart clear", 64'(vstart_clr_o), 64'd0);
            return;
        end
        for (int i = 0; i < vl; i++) begin
            for (int g = 0; g < gap; g++) begin
                elem_valid_i = 0;
                elem_i = 32'hDEAD_BEEF;
                @(negedge clk);
            end
            elem_valid_i = 1; elem_i = el[i]; elem_mask_i = mk[i];
            if (poke && i == 0) begin
                start_i = 1; vl_i = '0; sew_i = 2'd3;
            end
            @(negedge clk);
            start_i = 0;
        end
        elem_valid_i = 0;
        check(done_o && result_we_o && vstart_clr_o && !busy_o, "completion pulse",
              {60'd0, done_o, result_we_o, vstart_clr_o, busy_o}, 64'hE);
        check(result_o == exp_res, "final sum", result_o, exp_res);
        @(negedge clk);
        check(!done_o && !result_we_o, "single-cycle pulse",
              64'({done_o, result_we_o}), 64'd0);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 50000);
        if (!ended) begin
            ended = 1;
            fails++;
            checks++;
            $display("FAIL %s watchdog actual=%h expected=%h", cur_tag, 64'd0, 64'd1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] el [8];
        bit          all1 [8];
        bit          all0 [8];
        bit          m101 [8];
        all1 = '{1, 1, 1, 1, 1, 1, 1, 1};
        all0 = '{0, 0, 0, 0, 0, 0, 0, 0};
        m101 = '{1, 0, 1, 0, 0, 0, 0, 0};

        repeat (3) @(negedge clk);
        // R1: reset state
        check({busy_o, done_o, result_we_o, illegal_o, vstart_clr_o} == 5'd0,
              "R1 reset outputs", 64'({busy_o, done_o, result_we_o, illegal_o, vstart_clr_o}), 64'd0);
        rst_n = 1;
        @(negedge clk);

        // R3: zero extension, upper element bits ignored
        el = '{32'h0000_AAFF, 32'h1234_12FF, 32'h0000_0080, 32'h0000_0001, 0, 0, 0, 0};
        run_op("R3", 2'd0, 3'd0, 0, 4, 0, 64'h10, el, all1, 0, 0, 64'h28F, 0);
        // R4: sign extension: 16 - 1 - 1 - 128 + 1
        run_op("R4", 2'd0, 3'd0, 1, 4, 0, 64'h10, el, all1, 0, 0, 64'hFF8F, 0);
        // R5: wrap at 32 bits for SEW 16
        el = '{32'h0020, 32'h0001, 0, 0, 0, 0, 0, 0};
        run_op("R5", 2'd1, 3'd0, 0, 2, 0, 64'hFFFF_FFF0, el, all1, 0, 0, 64'h11, 0);
        // R5: wrap at 64 bits for SEW 32
        el = '{32'h1, 0, 0, 0, 0, 0, 0, 0};
        run_op("R5", 2'd2, 3'd0, 0, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF, el, all1, 0, 0, 64'h0, 0);
        // R2: seed above 2*SEW ignored
        el = '{32'hFFFE, 0, 0, 0, 0, 0, 0, 0};
        run_op("R2", 2'd1, 3'd0, 1, 1, 0, 64'hABCD_1234_0000_0005, el, all1, 0, 0, 64'h3, 0);
        // R6: masked elements skipped (lmul -1 legal at SEW 32)
        el = '{32'h5, 32'h8000_0000, 32'hFFFF_FFFD, 0, 0, 0, 0, 0};
        run_op("R6", 2'd2, 3'b111, 1, 3, 1, 64'd100, el, m101, 0, 0, 64'd102, 0);
        // R6: masking disabled counts every element
        el = '{32'h1, 32'h2, 32'h3, 0, 0, 0, 0, 0};
        run_op("R6", 2'd0, 3'd0, 0, 3, 0, 64'h0, el, all0, 0, 0, 64'h6, 0);
        // R7: idle gaps between strobes
        el = '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0, 0, 0};
        run_op("R7", 2'd2, 3'd0, 0, 3, 0, 64'h0, el, all1, 2, 0, 64'h2_FFFF_FFFD, 0);
        // R7: longest length here, eight elements
        el = '{32'h1, 32'h2, 32'h3, 32'h4, 32'h5, 32'h6, 32'h7, 32'h8};
        run_op("R7", 2'd1, 3'd0, 1, 8, 0, 64'h0, el, all1, 0, 0, 64'd36, 0);
        // R8: zero length
        run_op("R8", 2'd0, 3'd0, 0, 0, 0, 64'h55, el, all1, 0, 0, 64'h0, 1);
        // R9: illegal configurations
        run_op("R9", 2'd3, 3'd0, 0, 2, 0, 64'h0, el, all1, 0, 0, 64'h0, 2);
        run_op("R9", 2'd0, 3'b100, 0, 2, 0, 64'h0, el, all1, 0, 0, 64'h0, 2);
        run_op("R9", 2'd0, 3'b011, 0, 2, 0, 64'h0, el, all1, 0, 0, 64'h0, 2);
        run_op("R9", 2'd2, 3'b110, 0, 2, 0, 64'h0, el, all1, 0, 0, 64'h0, 2);
        // R9: largest legal multiplier
        el = '{32'h7, 0, 0, 0, 0, 0, 0, 0};
        run_op("R9", 2'd0, 3'b010, 0, 1, 0, 64'h1, el, all1, 0, 0, 64'h8, 0);
        // R1: start while busy is ignored
        el = '{32'h1, 32'h1, 0, 0, 0, 0, 0, 0};
        run_op("R1", 2'd0, 3'd0, 0, 2, 0, 64'h0, el, all1, 0, 1, 64'h2, 0);
        // R10: strobes while idle have no effect
        cur_tag = "R10";
        elem_valid_i = 1; elem_i = 32'hFF;
        repeat (3) @(negedge clk);
        elem_valid_i = 0;
        check(!busy_o && !done_o, "idle strobes", 64'({busy_o, done_o}), 64'd0);
        el = '{32'h3, 0, 0, 0, 0, 0, 0, 0};
        run_op("R10", 2'd0, 3'd0, 0, 1, 0, 64'h4, el, all1, 0, 0, 64'h7, 0);

        repeat (2) @(negedge clk);
        ended = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule